// File: doc/BRIEF.md
# GPIO Interrupt Source Selector

This block turns a wide bank of GPIO interrupt lines into a small set of interrupt channels for a parent interrupt controller. Each of the 32 channels picks one of up to 128 GPIO lines by a programmable source number and watches it with its own sense type: rising edge, falling edge, high level or low level. When a qualifying condition is seen on an enabled channel, a status bit is latched. That status bit is driven out as an active-high level request.

Software configures the channels through a simple 32-bit register bus with single-cycle writes and combinational reads. To retarget a channel, software first writes the new source with the enable bit clear. It then sets the sense type and clears any stale status, and enables the channel only after that. GPIO lines pass through a two-flop synchroniser before selection. A channel whose source or sense changes reloads its edge history from the new source, so the reconfiguration does not create an event of its own.

Top module: `gpio_irq_sel`

## Requirements
- R1: After reset every register reads 0, every channel is disabled and `irq_req` is all zeros.
- R2: Channel n is configured by the byte at bit offset 8*(n mod 4) of the select register at address 0x30 + 4*(n/4). Within that byte, bit 7 is the enable and bits 6:0 are the source number. The byte reads back as written.
- R3: The sense field of channel n is 2 bits wide at bit 2*(n mod 16). It sits in the register at 0x24 for channels 0-15 and at 0x28 for channels 16-31, and it reads back as written.
- R4: With sense 0 (rising edge), a 0-to-1 change of the selected GPIO line on an enabled channel sets the status bit. The status bit is first visible on `irq_req` and in the status register three rising clock edges after the input changes. A 1-to-0 change does not set the status bit.
- R5: With sense 1 (falling edge), a 1-to-0 change of the selected line sets the status bit and a 0-to-1 change does not.
- R6: With sense 2 (high level) or sense 3 (low level), the status bit of an enabled channel follows the selected line and clears itself when the level goes away.
- R7: Status bit n is at bit n of the register at 0x20. Writing 0 to a status bit clears it, and writing 1 leaves it unchanged.
- R8: A disabled channel never sets its status bit, whatever the selected line does. Enabling a channel whose line is already high in rising mode does not set the status bit.
- R9: Changing the source number or the sense of a channel does not by itself create an event, even when the old and new lines differ in level.
- R10: On a level-mode channel whose level condition is present, a software clear in the same cycle loses to the set, and the status bit stays 1.
- R11: Activity on GPIO lines that a channel has not selected has no effect on that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_irq_in | input | NUM_SRC | GPIO interrupt lines, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | NUM_CH | Active-high level requests, one per channel |

## Verification
The bench retargets an enabled channel from a low line to a high one. A design that failed to reload the edge history would see a false rising edge and raise a request that nobody asked for. It enables a rising channel while its line is already high, toggles lines next to the selected one, and toggles lines of disabled channels. Broken enable gating or a bad source multiplexer would latch status in those cases. It also clears a level channel while the level is present, and writes all ones to the status register. A design that let the clear win, or that treated 1 as a clear, would drop the request.

// File: rtl/gis_pkg.sv
package gis_pkg;
    localparam logic [1:0] SENSE_RISE = 2'd0;
    localparam logic [1:0] SENSE_FALL = 2'd1;
    localparam logic [1:0] SENSE_HIGH = 2'd2;
    localparam logic [1:0] SENSE_LOW  = 2'd3;

    localparam int OFS_STATUS   = 'h20;
    localparam int OFS_TYPE     = 'h24;
    localparam int OFS_SEL      = 'h30;
    localparam int CH_PER_TYPE  = 16;
    localparam int CH_PER_SEL   = 4;

    function automatic int sel_ofs(int ch);
        return OFS_SEL + 4 * (ch / CH_PER_SEL);
    endfunction

    function automatic int type_ofs(int ch);
        return OFS_TYPE + 4 * (ch / CH_PER_TYPE);
    endfunction
endpackage

// File: rtl/gis_sync.sv
module gis_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gis_regs.sv
module gis_regs
    import gis_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int SRC_W  = 7,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [31:0]                   wdata,
    input  logic [NUM_CH-1:0]             status_in,
    output logic [31:0]                   rdata,
    output logic [NUM_CH-1:0]             ch_en,
    output logic [NUM_CH-1:0][SRC_W-1:0]  ch_src,
    output logic [NUM_CH-1:0][1:0]        ch_sense,
    output logic [NUM_CH-1:0]             cfg_chg,
    output logic [NUM_CH-1:0]             sw_clr
);
    localparam logic [7:0] BYTE_MASK = 8'h80 | 8'((1 << SRC_W) - 1);

    typedef struct packed {
        logic [NUM_CH-1:0][7:0] cfg;
        logic [NUM_CH-1:0][1:0] sense;
        logic [NUM_CH-1:0]      chg;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d     = rg_q;
        rg_d.chg = '0;
        sw_clr   = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            logic [7:0] nb;
            logic [1:0] ns;
            nb = wdata[8*(ch % CH_PER_SEL) +: 8] & BYTE_MASK;
            ns = wdata[2*(ch % CH_PER_TYPE) +: 2];
            if (wr_en && int'(addr) == sel_ofs(ch)) begin
                rg_d.cfg[ch] = nb;
                if (nb[SRC_W-1:0] != rg_q.cfg[ch][SRC_W-1:0]) rg_d.chg[ch] = 1'b1;
            end
            if (wr_en && int'(addr) == type_ofs(ch)) begin
                rg_d.sense[ch] = ns;
                if (ns != rg_q.sense[ch]) rg_d.chg[ch] = 1'b1;
            end
            if (wr_en && int'(addr) == OFS_STATUS && !wdata[ch]) sw_clr[ch] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            ch_en[ch]    = rg_q.cfg[ch][7];
            ch_src[ch]   = rg_q.cfg[ch][SRC_W-1:0];
            ch_sense[ch] = rg_q.sense[ch];
            if (int'(addr) == sel_ofs(ch))  rdata[8*(ch % CH_PER_SEL) +: 8] = rg_q.cfg[ch];
            if (int'(addr) == type_ofs(ch)) rdata[2*(ch % CH_PER_TYPE) +: 2] = rg_q.sense[ch];
            if (int'(addr) == OFS_STATUS)   rdata[ch] = status_in[ch];
        end
    end

    assign cfg_chg = rg_q.chg;

    // R9: a reconfiguration flag only follows a bus write
    p_chg_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|rg_q.chg) |-> $past(wr_en));
endmodule

// File: rtl/gis_channel.sv
module gis_channel
    import gis_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int SRC_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] gpio_s,
    input  logic               en,
    input  logic [SRC_W-1:0]   src,
    input  logic [1:0]         sense,
    input  logic               cfg_chg,
    input  logic               sw_clr,
    output logic               status
);
    typedef struct packed {
        logic prev;
        logic status;
    } ch_t;

    ch_t  st_d, st_q;
    logic sel, rise, fall, lvl, armed;

    always_comb begin
        sel   = gpio_s[src];
        rise  = sel & ~st_q.prev;
        fall  = ~sel & st_q.prev;
        lvl   = (sense == SENSE_HIGH) ? sel : ~sel;
        armed = en & ~cfg_chg;

        st_d.prev   = sel;
        st_d.status = st_q.status & ~sw_clr;
        if (armed) begin
            if (sense[1])
                st_d.status = lvl;
            else if ((sense == SENSE_RISE && rise) || (sense == SENSE_FALL && fall))
                st_d.status = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;

    p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cfg_chg && sense == SENSE_RISE && sel && !st_q.prev) |=> status);
    p_fall_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cfg_chg && sense == SENSE_FALL && !sel && st_q.prev) |=> status);
    p_level_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cfg_chg && sense[1]) |=> (status == $past(lvl)));
    p_quiet_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !status) |=> !status);
    p_cfg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chg && !status) |=> !status);
    p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cfg_chg && sense[1] && lvl && sw_clr) |=> status);
endmodule

// File: rtl/gpio_irq_sel.sv
module gpio_irq_sel #(
    parameter int NUM_CH  = 32,
    parameter int NUM_SRC = 128,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] gpio_irq_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CH-1:0]  irq_req
);
    localparam int SRC_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]            gpio_s;
    logic [NUM_CH-1:0]             ch_en, cfg_chg, sw_clr, status;
    logic [NUM_CH-1:0][SRC_W-1:0]  ch_src;
    logic [NUM_CH-1:0][1:0]        ch_sense;

    gis_sync #(.W(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(gpio_irq_in), .sync_out(gpio_s)
    );

    gis_regs #(.NUM_CH(NUM_CH), .SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .status_in(status), .rdata(bus_rdata), .ch_en(ch_en), .ch_src(ch_src),
        .ch_sense(ch_sense), .cfg_chg(cfg_chg), .sw_clr(sw_clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gis_channel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .gpio_s(gpio_s), .en(ch_en[c]), .src(ch_src[c]),
            .sense(ch_sense[c]), .cfg_chg(cfg_chg[c]), .sw_clr(sw_clr[c]), .status(status[c])
        );
    end

    assign irq_req = status;

    // R1: nothing requests in the first cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_req == '0));
endmodule

// File: tb/gpio_irq_sel_bench.sv
`timescale 1ns/1ps
module gpio_irq_sel_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] gpio = '0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [31:0]  irq_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] sel_sh [8];
    logic [31:0] type_sh [2];

    always #4 clk = ~clk;

    gpio_irq_sel u_gpio_irq_sel (
        .clk(clk), .rst_n(rst_n), .gpio_irq_in(gpio), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_chan(input int n, input logic en, input logic [6:0] src);
        sel_sh[n/4][8*(n%4) +: 8] = {en, src};
        wr(8'(8'h30 + 4*(n/4)), sel_sh[n/4]);
    endtask

    task automatic set_sense(input int n, input logic [1:0] s);
        type_sh[n/16][2*(n%16) +: 2] = s;
        wr(8'(8'h24 + 4*(n/16)), type_sh[n/16]);
    endtask

    task automatic clr_status(input int n);
        wr(8'h20, ~(32'h1 << n));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq_req", irq_req, 32'h0);
        rd(8'h20, v); chk("R1 status", v, 0);
        rd(8'h24, v); chk("R1 type0", v, 0);
        rd(8'h28, v); chk("R1 type1", v, 0);
        for (int i = 0; i < 8; i++) begin
            rd(8'(8'h30 + 4*i), v); chk("R1 select", v, 0);
        end
    endtask

    task automatic t_layout();
        logic [31:0] v;
        set_chan(6, 1'b0, 7'd127);
        set_chan(5, 1'b1, 7'd3);
        rd(8'h34, v); chk("R2 select byte layout", v, 32'h007F8300);
        set_sense(17, 2'd1);
        rd(8'h28, v); chk("R3 type1 field", v, 32'h0000_0004);
        set_sense(15, 2'd3);
        rd(8'h24, v); chk("R3 type0 field", v, 32'hC000_0000);
        set_sense(15, 2'd0);
        set_chan(5, 1'b0, 7'd3);
        set_chan(6, 1'b0, 7'd0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        set_chan(0, 1'b1, 7'd10);
        @(negedge clk) gpio[10] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 not yet after two edges", 32'(irq_req[0]), 0);
        @(negedge clk);
        chk("R4 set on third edge", 32'(irq_req[0]), 1);
        rd(8'h20, v); chk("R4 status bit0", v, 32'h1);
        clr_status(0);
        rd(8'h20, v); chk("R7 write 0 clears", v, 32'h0);
        gpio[10] = 1'b0; settle();
        chk("R4 falling ignored in rise mode", 32'(irq_req[0]), 0);
    endtask

    task automatic t_fall();
        set_sense(17, 2'd1);
        set_chan(17, 1'b1, 7'd127);
        gpio[127] = 1'b1; settle();
        chk("R5 rising ignored in fall mode", 32'(irq_req[17]), 0);
        gpio[127] = 1'b0; settle();
        chk("R5 falling sets", 32'(irq_req[17]), 1);
        clr_status(17);
        chk("R5 cleared", 32'(irq_req[17]), 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        set_sense(8, 2'd2);
        set_chan(8, 1'b1, 7'd40);
        settle();
        chk("R6 high mode idle low", 32'(irq_req[8]), 0);
        gpio[40] = 1'b1; settle();
        chk("R6 high level sets", 32'(irq_req[8]), 1);
        clr_status(8);
        rd(8'h20, v); chk("R10 set beats clear", v, 32'h100);
        gpio[40] = 1'b0; settle();
        chk("R6 self clear on low", 32'(irq_req[8]), 0);
        set_sense(8, 2'd3); settle();
        chk("R6 low level sets", 32'(irq_req[8]), 1);
        set_chan(8, 1'b0, 7'd40);
        clr_status(8);
        settle();
        chk("R8 disabled level channel stays clear", 32'(irq_req[8]), 0);
    endtask

    task automatic t_disabled();
        set_chan(20, 1'b0, 7'd60);
        gpio[60] = 1'b1; settle();
        chk("R8 disabled rise ignored", 32'(irq_req[20]), 0);
        set_chan(20, 1'b1, 7'd60); settle();
        chk("R8 enable with high line no event", 32'(irq_req[20]), 0);
        gpio[60] = 1'b0; settle();
        gpio[60] = 1'b1; settle();
        chk("R8 enabled edge sets", 32'(irq_req[20]), 1);
        clr_status(20);
    endtask

    task automatic t_src_change();
        gpio[9] = 1'b1; gpio[5] = 1'b0; settle();
        set_chan(3, 1'b1, 7'd5); settle();
        chk("R9 start clear", 32'(irq_req[3]), 0);
        set_chan(3, 1'b1, 7'd9); settle();
        chk("R9 source switch no false edge", 32'(irq_req[3]), 0);
        set_sense(3, 2'd1); settle();
        chk("R9 sense switch no false edge", 32'(irq_req[3]), 0);
        set_sense(3, 2'd0);
        gpio[9] = 1'b0; settle();
        gpio[9] = 1'b1; settle();
        chk("R9 new source edge sets", 32'(irq_req[3]), 1);
        clr_status(3);
    endtask

    task automatic t_other_src();
        logic [31:0] v;
        set_chan(25, 1'b1, 7'd70); settle();
        gpio[69] = 1'b1; gpio[71] = 1'b1; settle();
        chk("R11 neighbours ignored", irq_req, 32'h0);
        gpio[70] = 1'b1; settle();
        chk("R11 selected line sets", irq_req, 32'h0200_0000);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R7 write 1 keeps", v, 32'h0200_0000);
        wr(8'h20, 32'hFDFF_FFFF);
        rd(8'h20, v); chk("R7 targeted clear", v, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) sel_sh[i] = '0;
        type_sh[0] = '0; type_sh[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_rise();
        t_fall();
        t_level();
        t_disabled();
        t_src_change();
        t_other_src();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule